// File: doc/BRIEF.md
# Line-Coded Preamble and Opening-Flag Detector

This block sits behind a bit-clock recovery stage. Each recovered line bit comes with a one-cycle strobe that is synchronous to the system clock. The block turns the transition-coded line into data bits: an unchanged level is a 1 and a changed level is a 0. It keeps the most recent decoded bits in a 16-bit shift register, filled from the top, for a downstream deframer.

At the same time the block searches the decoded stream for a training run of alternating bits followed by the 8-bit opening flag `0 1 1 1 1 1 1 0`. The two equal bits that end a long enough run are taken as the start of the flag. After a 0-0 ending, seven flag bits are still due. After a 1-1 ending, five are still due.

When the flag completes, a one-cycle sync pulse is issued and the search stops. It resumes only when the `restart` input is pulsed. If a search restarts after too many bits have gone by without success, the block reports a timeout. It then re-arms and flips its channel-select output, so that a receiver can alternate between two channels.

Top module: `nrzi_sync_detect`

## Requirements
- R1: On every cycle with `bit_stb` high, the decoded bit is the inverse of the XOR of the previous strobed line level and the current `line_bit`. After reset the previous level is taken as 0. `data_bit` carries the decoded bit and `data_valid` is high exactly one cycle after each strobe.
- R2: On each strobe, `shift_reg` shifts right by one and the new decoded bit enters bit 15. Bit 0 holds the oldest bit. The register is all zeros after reset.
- R3: A cycle with `bit_stb` low changes no state. `shift_reg`, `data_bit` and `chan_sel` keep their values even if `line_bit` toggles in that cycle.
- R4: A training run counts its alternations. When two equal consecutive decoded bits arrive and more than 8 alternations have been counted, the run is accepted. Otherwise the search restarts: the count clears and the repeated bit becomes the first bit of a new run.
- R5: After an accepted run that ends 0-0, 7 more flag bits are checked. After a run that ends 1-1, 5 more are checked. All of them except the last must be 1, and the last must be 0. `sync_found` pulses for one cycle, one clock after the strobe of that last bit.
- R6: A flag bit that violates R5 restarts the search in the same way as R4, and no sync pulse is issued.
- R7: The block counts evaluated bits since it last re-armed. If a search restart happens when that count exceeds 16, `timeout` pulses for one cycle and `chan_sel` flips. The block then re-arms.
- R8: After `sync_found`, further strobed bits produce no `sync_found`, no `timeout` and no change of `chan_sel` until `restart` is pulsed.
- R9: Synchronous reset clears `chan_sel`, `sync_found`, `timeout`, `data_bit` and `data_valid`. A pulse on `restart` flips `chan_sel` and re-arms the search. In both cases the first strobed bit afterwards only re-arms the search: it is decoded and shifted, but it is not checked as preamble or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking a recovered line bit |
| line_bit | input | 1 | Raw transition-coded line level |
| restart | input | 1 | Re-arm the search and flip the channel select |
| data_bit | output | 1 | Most recent decoded bit |
| data_valid | output | 1 | High one cycle after each strobe |
| shift_reg | output | 16 | Decoded history, newest bit in bit 15 |
| sync_found | output | 1 | One-cycle pulse when the opening flag completes |
| chan_sel | output | 1 | Receive channel select, flips on timeout and on restart |
| timeout | output | 1 | One-cycle pulse when the search times out |

## Verification
Every output is registered, so each result is due exactly one clock after the strobe or restart edge that causes it. No output lags by more than that one register. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares all outputs on the following falling edge, which is the first point at which the new values are settled. Strobes are spaced every other cycle, and the line is toggled in the gaps, so any update taken on a non-strobe cycle shows up one falling edge later as a mismatch.

// File: rtl/nrzi_sync_pkg.sv
package nrzi_sync_pkg;
  typedef enum logic [2:0] {
    ST_ARM,
    ST_SEEK,
    ST_LAST0,
    ST_LAST1,
    ST_FLAG,
    ST_DONE
  } hunt_st_t;

  localparam int FLAG_LEFT_AFTER_ZERO = 7;
  localparam int FLAG_LEFT_AFTER_ONE  = 5;
endpackage

// File: rtl/nrzi_line_decoder.sv
module nrzi_line_decoder #(
  parameter int SR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic            line_bit,
  output logic            dec_bit,
  output logic            data_bit,
  output logic            data_valid,
  output logic [SR_W-1:0] shift_reg
);
  logic prev_lvl;

  // same level -> 1, change -> 0
  always_comb dec_bit = ~(prev_lvl ^ line_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl   <= 1'b0;
      data_bit   <= 1'b0;
      data_valid <= 1'b0;
      shift_reg  <= '0;
    end else begin
      data_valid <= stb;
      if (stb) begin
        prev_lvl  <= line_bit;
        data_bit  <= dec_bit;
        shift_reg <= {dec_bit, shift_reg[SR_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/nrzi_flag_hunter.sv
module nrzi_flag_hunter
  import nrzi_sync_pkg::*;
#(
  parameter int PRE_LEN = 8,
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic bit_in,
  input  logic restart,
  output logic sync_found,
  output logic timeout,
  output logic chan_sel
);
  localparam int CNT_W = $clog2(TIMEOUT + 2);
  localparam int ALT_W = $clog2(PRE_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TIMEOUT);
  localparam logic [ALT_W-1:0] ALT_MAX = ALT_W'(PRE_LEN + 1);
  localparam logic [ALT_W-1:0] ALT_LIM = ALT_W'(PRE_LEN);

  hunt_st_t st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n, cnt_inc;
  logic [ALT_W-1:0] alt, alt_n, alt_inc;
  logic [2:0]       rem, rem_n, rem_dec;
  logic             chan_n, sync_n, tmo_n;

  always_comb begin
    cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    alt_inc = (alt == ALT_MAX) ? alt : alt + 1'b1;
    rem_dec = rem - 3'd1;
  end

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    alt_n  = alt;
    rem_n  = rem;
    chan_n = chan_sel;
    sync_n = 1'b0;
    tmo_n  = 1'b0;
    if (restart) begin
      st_n   = ST_ARM;
      chan_n = ~chan_sel;
    end else if (stb) begin
      if (st != ST_ARM && st != ST_DONE) cnt_n = cnt_inc;
      unique case (st)
        ST_ARM: begin
          cnt_n = '0;
          st_n  = ST_SEEK;
        end
        ST_LAST0, ST_LAST1: begin
          if (bit_in != (st == ST_LAST1)) begin
            alt_n = alt_inc;
            st_n  = bit_in ? ST_LAST1 : ST_LAST0;
          end else if (alt > ALT_LIM) begin
            rem_n = bit_in ? 3'(FLAG_LEFT_AFTER_ONE) : 3'(FLAG_LEFT_AFTER_ZERO);
            st_n  = ST_FLAG;
          end else begin
            st_n = ST_SEEK;
          end
        end
        ST_FLAG: begin
          rem_n = rem_dec;
          if (rem_dec != 3'd0) begin
            if (!bit_in) st_n = ST_SEEK;
          end else if (!bit_in) begin
            sync_n = 1'b1;
            st_n   = ST_DONE;
          end else begin
            st_n = ST_SEEK;
          end
        end
        default: ;
      endcase
      // restart action applied to the bit that triggered it
      if ((st == ST_SEEK) || (st_n == ST_SEEK && st != ST_ARM)) begin
        if (cnt_inc > CNT_LIM) begin
          st_n   = ST_ARM;
          chan_n = ~chan_sel;
          tmo_n  = 1'b1;
        end else begin
          alt_n = '0;
          st_n  = bit_in ? ST_LAST1 : ST_LAST0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_ARM;
      cnt        <= '0;
      alt        <= '0;
      rem        <= '0;
      chan_sel   <= 1'b0;
      sync_found <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      alt        <= alt_n;
      rem        <= rem_n;
      chan_sel   <= chan_n;
      sync_found <= sync_n;
      timeout    <= tmo_n;
    end
  end
endmodule

// File: rtl/nrzi_sync_detect.sv
module nrzi_sync_detect #(
  parameter int SR_W    = 16,
  parameter int PRE_LEN = 8,
  parameter int TIMEOUT = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_stb,
  input  logic            line_bit,
  input  logic            restart,
  output logic            data_bit,
  output logic            data_valid,
  output logic [SR_W-1:0] shift_reg,
  output logic            sync_found,
  output logic            chan_sel,
  output logic            timeout
);
  logic dec_bit;

  nrzi_line_decoder #(.SR_W(SR_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .stb        (bit_stb),
    .line_bit   (line_bit),
    .dec_bit    (dec_bit),
    .data_bit   (data_bit),
    .data_valid (data_valid),
    .shift_reg  (shift_reg)
  );

  nrzi_flag_hunter #(.PRE_LEN(PRE_LEN), .TIMEOUT(TIMEOUT)) u_hunt (
    .clk        (clk),
    .rst        (rst),
    .stb        (bit_stb),
    .bit_in     (dec_bit),
    .restart    (restart),
    .sync_found (sync_found),
    .timeout    (timeout),
    .chan_sel   (chan_sel)
  );
endmodule

// File: rtl/nrzi_sync_detect_chk.sv
module nrzi_sync_detect_chk #(
  parameter int SR_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            bit_stb,
  input logic            restart,
  input logic            data_valid,
  input logic [SR_W-1:0] shift_reg,
  input logic            sync_found,
  input logic            chan_sel,
  input logic            timeout
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R1
  data_valid_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    data_valid == $past(bit_stb));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(bit_stb) |-> $stable(shift_reg));

  // R5
  sync_pulse_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    sync_found |=> !sync_found);

  // R7
  chan_cause_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (chan_sel != $past(chan_sel)) |-> (timeout || $past(restart)));

  // R7
  timeout_flip_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    timeout |-> (chan_sel != $past(chan_sel)));

  // R8
  sync_excl_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !(sync_found && timeout));
endmodule

bind nrzi_sync_detect nrzi_sync_detect_chk #(.SR_W(SR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_stb    (bit_stb),
  .restart    (restart),
  .data_valid (data_valid),
  .shift_reg  (shift_reg),
  .sync_found (sync_found),
  .chan_sel   (chan_sel),
  .timeout    (timeout)
);

// File: tb/nrzi_sync_detect_bench.sv
module nrzi_sync_detect_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 1'b0, line_bit = 1'b0, restart = 1'b0;
  logic data_bit, data_valid, sync_found, chan_sel, timeout;
  logic [15:0] shift_reg;

  int n_cmp = 0, n_bad = 0, n_sync = 0, n_tmo = 0;
  bit done = 0, cmp_on = 0;
  bit lvl = 0;

  always #5 clk = ~clk;

  nrzi_sync_detect u_nrzi_sync_detect (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .line_bit(line_bit),
    .restart(restart), .data_bit(data_bit), .data_valid(data_valid),
    .shift_reg(shift_reg), .sync_found(sync_found), .chan_sel(chan_sel),
    .timeout(timeout)
  );

  // behavioural model: 0 arm, 1 seek, 2 last was 0, 3 last was 1, 4 flag, 5 done
  int m_st, m_cnt, m_alt, m_rem;
  bit m_prev, m_chan, m_sync, m_tmo, m_db, m_dv;
  bit [15:0] m_sr;

  task automatic m_again(input bit b);
    if (m_cnt > 16) begin
      m_st = 0; m_chan = !m_chan; m_tmo = 1;
    end else begin
      m_alt = 0; m_st = b ? 3 : 2;
    end
  endtask

  always @(posedge clk) begin
    bit b;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_alt = 0; m_rem = 0; m_prev = 0; m_chan = 0;
      m_sync = 0; m_tmo = 0; m_db = 0; m_dv = 0; m_sr = '0;
    end else begin
      m_sync = 0; m_tmo = 0; m_dv = bit_stb;
      b = !(m_prev ^ line_bit);
      if (bit_stb) begin
        m_prev = line_bit; m_db = b; m_sr = {b, m_sr[15:1]};
      end
      if (restart) begin
        m_st = 0; m_chan = !m_chan;
      end else if (bit_stb) begin
        if (m_st != 0 && m_st != 5) m_cnt++;
        case (m_st)
          0: begin m_cnt = 0; m_st = 1; end
          1: m_again(b);
          2, 3: begin
            if (b != (m_st == 3)) begin m_alt++; m_st = b ? 3 : 2; end
            else if (m_alt > 8) begin m_rem = b ? 5 : 7; m_st = 4; end
            else m_again(b);
          end
          4: begin
            m_rem--;
            if (m_rem != 0) begin if (!b) m_again(b); end
            else if (!b) begin m_sync = 1; m_st = 5; end
            else m_again(b);
          end
          default: ;
        endcase
      end
    end
  end

  task automatic cmp1(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp1("R1 data_bit", data_bit, m_db);
    cmp1("R1 data_valid", data_valid, m_dv);
    cmp1("R2 shift_reg", shift_reg, m_sr);
    cmp1("R5 sync_found", sync_found, m_sync);
    cmp1("R7 chan_sel", chan_sel, m_chan);
    cmp1("R7 timeout", timeout, m_tmo);
    if (sync_found) n_sync++;
    if (timeout) n_tmo++;
  endtask

  task automatic tick(input bit s, input bit l, input bit r);
    @(negedge clk);
    if (cmp_on) compare_all();
    bit_stb = s; line_bit = l; restart = r;
  endtask

  // R3: idle cycle between strobes toggles the line
  task automatic send_bit(input bit b);
    lvl = b ? lvl : ~lvl;
    tick(1, lvl, 0);
    tick(0, ~lvl, 0);
  endtask

  task automatic send_pre(input bit first, input int n);
    for (int i = 0; i < n; i++) send_bit(first ^ i[0]);
  endtask

  task automatic send_flag_tail(input int ones);
    for (int i = 0; i < ones; i++) send_bit(1);
    send_bit(0);
  endtask

  task automatic do_restart();
    tick(0, lvl, 1);
    tick(0, lvl, 0);
    n_sync = 0; n_tmo = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit c0;
    repeat (3) @(negedge clk);
    // R9 reset state
    cmp1("R9 reset chan_sel", chan_sel, 0);
    cmp1("R9 reset sync_found", sync_found, 0);
    cmp1("R9 reset timeout", timeout, 0);
    cmp1("R2 reset shift_reg", shift_reg, 0);
    rst = 0;
    cmp_on = 1;

    // R3: no strobe, line toggling
    for (int i = 0; i < 6; i++) tick(0, i[0], 0);
    cmp1("R3 idle shift_reg", shift_reg, 0);

    // R4 R5: long run ending 0-0
    send_bit(1);
    send_pre(0, 11);
    send_bit(0);
    send_flag_tail(6);
    tick(0, lvl, 0);
    cmp1("R5 sync after 0-0 end", n_sync, 1);
    cmp1("R7 no timeout in good frame", n_tmo, 0);

    // R8: idle after sync
    c0 = chan_sel; n_sync = 0; n_tmo = 0;
    send_bit(0);
    send_pre(0, 11);
    send_bit(0);
    send_flag_tail(6);
    for (int i = 0; i < 20; i++) send_bit(1);
    tick(0, lvl, 0);
    cmp1("R8 no sync while done", n_sync, 0);
    cmp1("R8 no timeout while done", n_tmo, 0);
    cmp1("R8 chan stable while done", chan_sel, c0);

    // R9: restart flips channel; R5 run ending 1-1
    do_restart();
    cmp1("R9 restart flips chan", chan_sel, !c0);
    send_bit(0);
    send_pre(0, 10);
    send_bit(1);
    send_flag_tail(4);
    tick(0, lvl, 0);
    cmp1("R5 sync after 1-1 end", n_sync, 1);

    // R4: short run then flag
    do_restart();
    send_bit(1);
    send_pre(0, 6);
    send_bit(1);
    send_flag_tail(5);
    tick(0, lvl, 0);
    cmp1("R4 short run no sync", n_sync, 0);

    // R6: flag violation then recovery
    do_restart();
    send_bit(1);
    send_pre(0, 11);
    send_bit(0);
    send_bit(1); send_bit(1); send_bit(0);
    tick(0, lvl, 0);
    cmp1("R6 violation no sync", n_sync, 0);
    send_pre(1, 9);
    send_bit(1);
    send_flag_tail(4);
    tick(0, lvl, 0);
    cmp1("R6 recovery sync", n_sync, 1);
    cmp1("R6 recovery no timeout", n_tmo, 0);

    // R7: constant ones force timeout on 18th strobe
    do_restart();
    c0 = chan_sel;
    for (int i = 0; i < 17; i++) send_bit(1);
    tick(0, lvl, 0);
    cmp1("R7 no timeout before limit", n_tmo, 0);
    send_bit(1);
    tick(0, lvl, 0);
    cmp1("R7 timeout count", n_tmo, 1);
    cmp1("R7 chan flipped by timeout", chan_sel, !c0);

    // R1 R2: mixed pattern
    for (int i = 0; i < 40; i++) send_bit(((i * 7) % 5) < 2);
    tick(0, lvl, 0);
    finish_run();
  end
endmodule